// File: doc/BRIEF.md
# Burst-of-two quad-data-rate SRAM model

A synthesizable behavioural model of a static memory with a read data port and a write data port that work in parallel. The two ports share one address bus. The read address is taken on the rising edge of the main clock `clk_k`. The write address is taken half a cycle later, on the rising edge of the complementary clock `clk_kn`. Every address holds a pair of words. Each access moves that pair as a two-word burst, one word per half-cycle, so no bus turnaround is ever needed.

Each port has its own active-low select, which allows depth expansion. Both selects are sampled on `clk_k` only. Write data carry active-low byte-lane enables. Read data come out of a fixed pipeline that uses the main and complementary clocks as the output clocks. A valid flag frames the burst, and the output stays at zero when no burst is being driven. The array depth is a parameter and is kept small so the model runs quickly in simulation.

Top module: `qdr2_sram`

## Requirements
- R1: A read and a write may both be requested in the same `clk_k` cycle, and both take effect.
- R2: The read address is sampled from `addr` at the rising edge of `clk_k`. The write address is sampled from the same `addr` bus at the following rising edge of `clk_kn`.
- R3: Every access moves two words per address: word 0 (the low half of the array) and then word 1 (the high half). Write word 0 is sampled from `wdata` at `clk_k`, and write word 1 is sampled at the following `clk_kn`.
- R4: For a read requested at `clk_k` edge n, word 0 is on `rdata` after the `clk_kn` edge of cycle n+1, which is 1.5 cycles later. Word 1 is on `rdata` after `clk_k` edge n+2. `rvalid` is high during both half-cycles.
- R5: When no burst is being driven, `rvalid` is 0 and `rdata` is all zeros.
- R6: `rd_sel_n` high at a `clk_k` edge means no read takes place, and that slot of the output stays idle.
- R7: `wr_sel_n` high at a `clk_k` edge means nothing is written in that cycle, whatever values `addr`, `wdata` and `wbe_n` carry.
- R8: `wbe_n` bit b, when 0, writes bits [9b+8:9b] of the current word. When the bit is 1, those bits keep their stored value. The enables for word 0 are sampled with word 0, and the enables for word 1 with word 1.
- R9: A read and a write to the same address in the same cycle make the read return the data stored before that write. A read in the following cycle returns the new data.
- R10: After reset, `rvalid` is 0 and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Main clock. Samples the read address, the selects, write word 0 and its enables. |
| clk_kn | input | 1 | Complementary clock. Samples the write address, write word 1 and its enables. |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output state. |
| rd_sel_n | input | 1 | Active-low read port select. |
| wr_sel_n | input | 1 | Active-low write port select. |
| addr | input | ADDR_W | Shared address bus. Carries the read address at `clk_k` and the write address at `clk_kn`. |
| wdata | input | BYTE_W*LANES | Write data, one word per half-cycle. |
| wbe_n | input | LANES | Active-low byte-lane write enables for the current word. |
| rdata | output | BYTE_W*LANES | Read data, one word per half-cycle. |
| rvalid | output | 1 | High while a read burst word is on `rdata`. |

## Verification
A read and a write can land on the same address in the same cycle. The read samples the array at `clk_k`, and the write commits at the following `clk_kn`. The bench provokes this with a directed cycle that hits one address with both ports and uses new data. It expects the burst to return the old pair, and it expects a read in the next cycle to return the new pair. The bench also runs random interleaved cycles in which both ports are active together. Its reference array is updated only after the read expectation of each cycle has been taken, so every collision in the random stream is judged by the same ordering.

// File: rtl/qdr2_sram.sv
module qdr2_sram #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              clk_k,
  input  logic              clk_kn,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wbe_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_lo [DEPTH];
  logic [WORD_W-1:0] mem_hi [DEPTH];

  logic              wr_go;
  logic [WORD_W-1:0] wd_lo;
  logic [LANES-1:0]  be_lo;

  logic              rd_s0, rd_s1;
  logic [WORD_W-1:0] rb0_lo, rb0_hi, rb1_lo, rb1_hi;
  logic [WORD_W-1:0] oq_lo, oq_hi;
  logic              ov_lo, ov_hi;
  logic              tk, tn;
  logic              half_hi;

  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) begin
      wr_go  <= 1'b0;
      wd_lo  <= '0;
      be_lo  <= '1;
      rd_s0  <= 1'b0;
      rd_s1  <= 1'b0;
      rb0_lo <= '0;
      rb0_hi <= '0;
      rb1_lo <= '0;
      rb1_hi <= '0;
      oq_hi  <= '0;
      ov_hi  <= 1'b0;
      tk     <= 1'b0;
    end else begin
      wr_go <= ~wr_sel_n;
      wd_lo <= wdata;
      be_lo <= wbe_n;
      rd_s0 <= ~rd_sel_n;
      if (!rd_sel_n) begin
        rb0_lo <= mem_lo[addr];
        rb0_hi <= mem_hi[addr];
      end
      rd_s1  <= rd_s0;
      rb1_lo <= rb0_lo;
      rb1_hi <= rb0_hi;
      ov_hi  <= rd_s1;
      oq_hi  <= rd_s1 ? rb1_hi : '0;
      tk     <= ~tk;
    end
  end

  always_ff @(posedge clk_kn or negedge rst_n) begin
    if (!rst_n) begin
      oq_lo <= '0;
      ov_lo <= 1'b0;
      tn    <= 1'b0;
    end else begin
      ov_lo <= rd_s1;
      oq_lo <= rd_s1 ? rb1_lo : '0;
      tn    <= tk;
    end
  end

  always_ff @(posedge clk_kn) begin
    if (rst_n && wr_go) begin
      for (int b = 0; b < LANES; b++) begin
        if (!be_lo[b]) mem_lo[addr][b*BYTE_W +: BYTE_W] <= wd_lo[b*BYTE_W +: BYTE_W];
        if (!wbe_n[b]) mem_hi[addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign half_hi = tk ^ tn;
  assign rvalid  = half_hi ? ov_hi : ov_lo;
  assign rdata   = half_hi ? oq_hi : oq_lo;

  assert_read_latency_R4: assert property (@(posedge clk_k) disable iff (!rst_n)
    !rd_sel_n |-> ##2 rvalid);

  assert_read_deselect_R6: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_sel_n |-> ##2 !rvalid);

  assert_idle_zero_R5: assert property (@(posedge clk_kn) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    assert_lane_masked_R8: assert property (@(posedge clk_kn) disable iff (!rst_n)
      (wr_go && wbe_n[g]) |=>
        mem_hi[$past(addr)][g*BYTE_W +: BYTE_W] == $past(mem_hi[addr][g*BYTE_W +: BYTE_W]));
  end
endmodule

// File: tb/qdr2_sram_bench.sv
module qdr2_sram_bench;
  localparam int AW = 4;
  localparam int BW = 9;
  localparam int LN = 2;
  localparam int WW = BW * LN;
  localparam int DP = 1 << AW;

  logic          clk_k = 1'b0;
  logic          clk_kn;
  logic          rst_n;
  logic          rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] wdata;
  logic [LN-1:0] wbe_n;
  logic [WW-1:0] rdata;
  logic          rvalid;

  always #4 clk_k = ~clk_k;
  assign clk_kn = ~clk_k;

  qdr2_sram #(.ADDR_W(AW), .BYTE_W(BW), .LANES(LN)) u_qdr2_sram (
    .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid));

  int checks = 0;
  int fails  = 0;

  logic [WW-1:0] ref0 [DP];
  logic [WW-1:0] ref1 [DP];

  logic          p0v = 1'b0, p1v = 1'b0;
  logic [WW-1:0] p0e0, p0e1, p1e1;
  string         p0t = "R5", p1t = "R5";

  function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw, logic [LN-1:0] be);
    logic [WW-1:0] r = old;
    for (int b = 0; b < LN; b++)
      if (!be[b]) r[b*BW +: BW] = nw[b*BW +: BW];
    return r;
  endfunction

  task automatic chk(input logic v, input logic [WW-1:0] e, input string tag, input string what);
    logic ok;
    checks++;
    if (v) ok = (rvalid === 1'b1) && (rdata === e);
    else   ok = (rvalid === 1'b0) && (rdata === '0);
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual valid=%b data=%h expected valid=%b data=%h",
               tag, what, rvalid, rdata, v, v ? e : '0);
    end
  endtask

  task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                     input logic [WW-1:0] w0, input logic [LN-1:0] b0,
                     input logic [WW-1:0] w1, input logic [LN-1:0] b1, input string tag);
    logic          nv = rd;
    logic [WW-1:0] ne0 = ref0[ra];
    logic [WW-1:0] ne1 = ref1[ra];
    rd_sel_n = !rd; wr_sel_n = !wr; addr = ra; wdata = w0; wbe_n = b0;
    @(posedge clk_k); #1;
    chk(p1v, p1e1, p1t, "word1");
    addr = wa; wdata = w1; wbe_n = b1;
    @(posedge clk_kn); #1;
    if (wr) begin
      ref0[wa] = merge(ref0[wa], w0, b0);
      ref1[wa] = merge(ref1[wa], w1, b1);
    end
    chk(p0v, p0e0, p0t, "word0");
    p1v = p0v; p1e1 = p0e1; p1t = p0t;
    p0v = nv;  p0e0 = ne0; p0e1 = ne1; p0t = rd ? tag : "R5";
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, '0, '1, '0, '1, "R5");
  endtask

  task automatic t_reset;
    chk(1'b0, '0, "R10", "reset");
  endtask

  task automatic t_fill;
    for (int a = 0; a < DP; a++)
      cyc(0, '0, 1, AW'(a), WW'(18'h01000 + a), '0, WW'(18'h2A000 + a), '0, "R3");
  endtask

  task automatic t_readback;
    for (int a = 0; a < DP; a++) cyc(1, AW'(a), 0, '0, '0, '1, '0, '1, "R4");
    idle(2);
  endtask

  task automatic t_concurrent;
    for (int a = 0; a < DP; a++)
      cyc(1, AW'(a), 1, AW'((a + 5) % DP), WW'(18'h15500 ^ a), '0, WW'(18'h0AA00 ^ a), '0, "R1 R2");
    for (int a = 0; a < DP; a++) cyc(1, AW'(a), 0, '0, '0, '1, '0, '1, "R2");
    idle(2);
  endtask

  task automatic t_same_addr;
    cyc(1, 4'd7, 1, 4'd7, 18'h3FFFF, '0, 18'h12345, '0, "R9");
    cyc(1, 4'd7, 0, '0, '0, '1, '0, '1, "R9");
    idle(2);
  endtask

  task automatic t_bytes;
    cyc(0, '0, 1, 4'd3, 18'h3FE01, 2'b10, 18'h3FE01, 2'b01, "R8");
    cyc(1, 4'd3, 0, '0, '0, '1, '0, '1, "R8");
    cyc(0, '0, 1, 4'd3, 18'h00000, 2'b11, 18'h00000, 2'b11, "R8");
    cyc(1, 4'd3, 0, '0, '0, '1, '0, '1, "R8");
    idle(2);
  endtask

  task automatic t_deselect;
    cyc(0, 4'd9, 0, 4'd9, 18'h2BEEF, '0, 18'h1CAFE, '0, "R7");
    cyc(1, 4'd9, 0, '0, '0, '1, '0, '1, "R7");
    cyc(0, 4'd9, 0, '0, '0, '1, '0, '1, "R6");
    cyc(1, 4'd10, 0, '0, '0, '1, '0, '1, "R6");
    cyc(0, 4'd10, 0, '0, '0, '1, '0, '1, "R6");
    idle(2);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 3) != 0, AW'($urandom), ($urandom % 3) != 0, AW'($urandom),
          WW'($urandom), LN'($urandom), WW'($urandom), LN'($urandom), "R1 R9");
    idle(3);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog (all requirements): actual still running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    addr = '0; wdata = '0; wbe_n = '1;
    repeat (3) @(posedge clk_k);
    #2 rst_n = 1'b1;
    @(posedge clk_kn); #1;
    t_reset();
    t_fill();
    t_readback();
    t_concurrent();
    t_same_addr();
    t_bytes();
    t_deselect();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule